// File: doc/BRIEF.md
# IDE DMA transfer sequencer

This block runs one DMA transfer between a descriptor-driven DMA channel and a disk or optical drive model. A start request arms it. The request carries the drive kind, a sector count or packet byte size, a starting LBA and a command. The block sets up its byte counters, raises its active flag and sends a one-cycle kick to the channel.

The channel then offers chunks, each an address and a byte length. For each chunk the block does one of the following:
- stalls it, because the transfer is not armed;
- closes the burst, for a zero-length chunk;
- finishes the transfer, because nothing is left;
- aborts with an error;
- issues a request on a request/acknowledge storage port.

An issued request carries the drive byte offset and the operation. Disks use 512-byte sector scaling. Optical drives use 2048-byte block scaling and read only. An optical transfer with an all-ones LBA is a non-block copy: one truncated chunk, then the command is reported done. Once the storage acknowledge arrives, the burst or the whole transfer is closed toward the channel.

Top module: `ide_dma_seq`

## Requirements
- R1: After a synchronous reset the block has `active_o`=0, `req_o`=0, `resp_valid_o`=0, `status_o`=0x00, and both counters at 0.
- R2: A start accepted while no request is outstanding does the following. One cycle later the index reads 0. The remaining count reads `pkt_len_i` when `kind_i`=1 (optical) and `nsect_i`×512 when `kind_i`=0 (disk). Also `active_o`=1, `status_o`=0x80 and `kick_o` pulses for one cycle.
- R3: A chunk offered while `active_o`=0 gives response code 1 (stall). It has no `dma_end_o`, no request and no counter change.
- R4: A chunk offered while the remaining count is ≤0 finishes the transfer. The response is code 3 (done) with a `dma_end_o` pulse, and `active_o` clears. A disk also gets `status_o`=0x50 and an `irq_o` pulse. An optical drive gets an `ok_o` pulse instead.
- R5: A zero-length chunk on an armed transfer with bytes left gives response code 2 (burst end) and a `dma_end_o` pulse. `active_o` and the counters are unchanged.
- R6: An issued request holds `req_addr_o` = chunk address and `req_len_o` = chunk length. For a disk `req_off_o` = LBA×512 + index. For an optical drive it is LBA×2048 + index. The request fields stay stable until `ack_i`.
- R7: Issuing a block chunk subtracts its length from the remaining count and adds it to the index. Both updates are visible with the request.
- R8: A good acknowledge ends the burst. If the remaining count is then ≤0, the transfer finishes as in R4. Otherwise the response is code 2 with a `dma_end_o` pulse.
- R9: An optical transfer with an all-ones LBA issues op 3 (copy) with `req_off_o`=0. Its length is the lesser of remaining and chunk length, and the remaining count is set to that value. A good acknowledge then finishes the transfer as an optical finish, with no overflow check.
- R10: For a disk, command 0/1/2 issues op 0 (read), 1 (write) or 2 (trim). Command 3 aborts with response code 4 and no request. An optical block chunk always issues op 0.
- R11: An acknowledge with `err_i`=1 aborts the transfer. The response is code 4 with `dma_end_o` and `err_o` pulses, `status_o` becomes 0x41 and `active_o` clears.
- R12: On the block paths, a chunk longer than the remaining count aborts as in R11, with no request issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm a new transfer |
| kind_i | input | 1 | 0 disk, 1 optical |
| nsect_i | input | SECT_W | Disk sector count |
| pkt_len_i | input | LEN_W | Optical packet byte size |
| lba_i | input | LBA_W | Starting LBA |
| cmd_i | input | 2 | 0 read, 1 write, 2 trim, 3 illegal |
| kick_o | output | 1 | Pulse to restart the DMA channel |
| active_o | output | 1 | Transfer armed |
| chunk_valid_i | input | 1 | Chunk offered (one cycle) |
| chunk_addr_i | input | ADDR_W | Chunk memory address |
| chunk_len_i | input | LEN_W | Chunk byte length |
| resp_valid_o | output | 1 | Chunk response pulse |
| resp_code_o | output | 3 | 1 stall, 2 burst end, 3 done, 4 error |
| dma_end_o | output | 1 | Channel end handshake pulse |
| req_o | output | 1 | Storage request outstanding |
| req_op_o | output | 2 | 0 read, 1 write, 2 trim, 3 copy |
| req_addr_o | output | ADDR_W | Memory address of request |
| req_off_o | output | OFF_W | Drive byte offset |
| req_len_o | output | LEN_W | Request byte length |
| ack_i | input | 1 | Storage acknowledge (one cycle) |
| err_i | input | 1 | Storage error, valid with ack_i |
| irq_o | output | 1 | Disk completion interrupt pulse |
| ok_o | output | 1 | Optical command-OK pulse |
| err_o | output | 1 | Abort pulse |
| status_o | output | 8 | Drive status byte |
| dbg_rem_o | output | CNT_W | Remaining bytes (two's complement) |
| dbg_idx_o | output | CNT_W | Consumed byte index |

## Verification
The bench builds the block with SECT_W=4, LEN_W=12 and LBA_W=8, which gives CNT_W=14 and OFF_W=20. At these widths a full 15-sector disk transfer and a 4095-byte chunk both fit, and so does the top LBA of 255 with its widest offset. An 8-bit all-ones LBA is also easy to drive, so the non-block copy path can be reached. The small counters keep the worst offset and the remaining-count arithmetic inside a range that is easy to compute by hand.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_TRIM  = 2'd2,
    OP_COPY  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_STALL = 3'd1,
    RSP_BURST = 3'd2,
    RSP_DONE  = 3'd3,
    RSP_ERR   = 3'd4
  } rsp_e;

  localparam logic [7:0] ST_BUSY = 8'h80;
  localparam logic [7:0] ST_DONE = 8'h50;
  localparam logic [7:0] ST_FAIL = 8'h41;

  localparam int DISK_SHIFT = 9;
  localparam int OPT_SHIFT  = 11;
endpackage

// File: rtl/ide_dma_count.sv
module ide_dma_count #(
  parameter int SECT_W = 8,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    load_kind,
  input  logic [SECT_W-1:0]       load_nsect,
  input  logic [LEN_W-1:0]        load_pkt,
  input  logic                    sub_en,
  input  logic [LEN_W-1:0]        sub_len,
  input  logic                    clamp_en,
  input  logic [LEN_W-1:0]        clamp_len,
  output logic signed [CNT_W-1:0] rem,
  output logic [CNT_W-1:0]        idx
);
  localparam int SECT_PAD = CNT_W - SECT_W - ide_dma_pkg::DISK_SHIFT;
  localparam int LEN_PAD  = CNT_W - LEN_W;

  logic [CNT_W-1:0] disk_bytes;
  logic [CNT_W-1:0] pkt_bytes;
  logic [CNT_W-1:0] sub_ext;
  logic [CNT_W-1:0] clamp_ext;

  assign disk_bytes = {{SECT_PAD{1'b0}}, load_nsect, {ide_dma_pkg::DISK_SHIFT{1'b0}}};
  assign pkt_bytes  = {{LEN_PAD{1'b0}}, load_pkt};
  assign sub_ext    = {{LEN_PAD{1'b0}}, sub_len};
  assign clamp_ext  = {{LEN_PAD{1'b0}}, clamp_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      idx <= '0;
    end else if (load) begin
      rem <= load_kind ? signed'(pkt_bytes) : signed'(disk_bytes);
      idx <= '0;
    end else if (sub_en) begin
      rem <= rem - signed'(sub_ext);
      idx <= idx + sub_ext;
    end else if (clamp_en) begin
      rem <= signed'(clamp_ext);
    end
  end
endmodule

// File: rtl/ide_dma_offset.sv
module ide_dma_offset #(
  parameter int LBA_W = 24,
  parameter int CNT_W = 18,
  parameter int OFF_W = 36
) (
  input  logic             optical,
  input  logic [LBA_W-1:0] lba,
  input  logic [CNT_W-1:0] idx,
  output logic [OFF_W-1:0] offset
);
  logic [OFF_W-1:0] lba_ext;
  logic [OFF_W-1:0] idx_ext;
  logic [OFF_W-1:0] base;

  assign lba_ext = {{(OFF_W-LBA_W){1'b0}}, lba};
  assign idx_ext = {{(OFF_W-CNT_W){1'b0}}, idx};
  assign base    = optical ? (lba_ext << ide_dma_pkg::OPT_SHIFT)
                           : (lba_ext << ide_dma_pkg::DISK_SHIFT);
  assign offset  = base + idx_ext;
endmodule

// File: rtl/ide_dma_ctrl.sv
module ide_dma_ctrl
  import ide_dma_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int LBA_W  = 24,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 18,
  parameter int OFF_W  = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    kind_i,
  input  logic [LBA_W-1:0]        lba_i,
  input  logic [1:0]              cmd_i,
  input  logic                    chunk_valid_i,
  input  logic [ADDR_W-1:0]       chunk_addr_i,
  input  logic [LEN_W-1:0]        chunk_len_i,
  input  logic                    ack_i,
  input  logic                    err_i,
  input  logic signed [CNT_W-1:0] rem,
  input  logic [OFF_W-1:0]        offset,
  output logic                    kind_q,
  output logic [LBA_W-1:0]        lba_q,
  output logic                    cnt_load,
  output logic                    cnt_sub,
  output logic                    cnt_clamp,
  output logic [LEN_W-1:0]        copy_len,
  output logic                    kick_o,
  output logic                    active_o,
  output logic                    resp_valid_o,
  output logic [2:0]              resp_code_o,
  output logic                    dma_end_o,
  output logic                    req_o,
  output logic [1:0]              req_op_o,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [OFF_W-1:0]        req_off_o,
  output logic [LEN_W-1:0]        req_len_o,
  output logic                    irq_o,
  output logic                    ok_o,
  output logic                    err_o,
  output logic [7:0]              status_o
);
  typedef enum logic [0:0] {S_IDLE, S_WAIT} state_e;
  typedef enum logic [2:0] {
    D_NONE, D_START, D_STALL, D_FIN, D_BURST, D_COPY, D_FAIL, D_ISSUE
  } dec_e;

  state_e           state;
  dec_e             dec;
  logic [1:0]       cmd_q;
  logic             copy_q;
  logic             nonblock;
  logic             ended;
  logic signed [CNT_W-1:0] len_s;

  assign len_s    = signed'({{(CNT_W-LEN_W){1'b0}}, chunk_len_i});
  assign nonblock = kind_q && (lba_q == {LBA_W{1'b1}});
  assign ended    = (rem <= 0);
  assign copy_len = (len_s > rem) ? rem[LEN_W-1:0] : chunk_len_i;

  always_comb begin
    dec = D_NONE;
    if (state == S_IDLE) begin
      if (start_i)                                   dec = D_START;
      else if (chunk_valid_i) begin
        if (!active_o)                               dec = D_STALL;
        else if (ended)                              dec = D_FIN;
        else if (chunk_len_i == '0)                  dec = D_BURST;
        else if (nonblock)                           dec = D_COPY;
        else if ((!kind_q && cmd_q == 2'd3) || len_s > rem) dec = D_FAIL;
        else                                         dec = D_ISSUE;
      end
    end
  end

  assign cnt_load  = (dec == D_START);
  assign cnt_sub   = (dec == D_ISSUE);
  assign cnt_clamp = (dec == D_COPY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      kind_q       <= 1'b0;
      lba_q        <= '0;
      cmd_q        <= '0;
      copy_q       <= 1'b0;
      kick_o       <= 1'b0;
      active_o     <= 1'b0;
      resp_valid_o <= 1'b0;
      resp_code_o  <= RSP_NONE;
      dma_end_o    <= 1'b0;
      req_o        <= 1'b0;
      req_op_o     <= OP_READ;
      req_addr_o   <= '0;
      req_off_o    <= '0;
      req_len_o    <= '0;
      irq_o        <= 1'b0;
      ok_o         <= 1'b0;
      err_o        <= 1'b0;
      status_o     <= 8'h00;
    end else begin
      kick_o       <= 1'b0;
      resp_valid_o <= 1'b0;
      dma_end_o    <= 1'b0;
      irq_o        <= 1'b0;
      ok_o         <= 1'b0;
      err_o        <= 1'b0;
      case (dec)
        D_START: begin
          kind_q   <= kind_i;
          lba_q    <= lba_i;
          cmd_q    <= cmd_i;
          active_o <= 1'b1;
          kick_o   <= 1'b1;
          status_o <= ST_BUSY;
        end
        D_STALL: begin
          resp_valid_o <= 1'b1;
          resp_code_o  <= RSP_STALL;
        end
        D_FIN: begin
          resp_valid_o <= 1'b1;
          resp_code_o  <= RSP_DONE;
          dma_end_o    <= 1'b1;
          active_o     <= 1'b0;
          if (kind_q) ok_o <= 1'b1;
          else begin
            irq_o    <= 1'b1;
            status_o <= ST_DONE;
          end
        end
        D_BURST: begin
          resp_valid_o <= 1'b1;
          resp_code_o  <= RSP_BURST;
          dma_end_o    <= 1'b1;
        end
        D_FAIL: begin
          resp_valid_o <= 1'b1;
          resp_code_o  <= RSP_ERR;
          dma_end_o    <= 1'b1;
          err_o        <= 1'b1;
          active_o     <= 1'b0;
          status_o     <= ST_FAIL;
        end
        D_COPY: begin
          state      <= S_WAIT;
          copy_q     <= 1'b1;
          req_o      <= 1'b1;
          req_op_o   <= OP_COPY;
          req_addr_o <= chunk_addr_i;
          req_off_o  <= '0;
          req_len_o  <= copy_len;
        end
        D_ISSUE: begin
          state      <= S_WAIT;
          copy_q     <= 1'b0;
          req_o      <= 1'b1;
          req_op_o   <= kind_q ? OP_READ : cmd_q;
          req_addr_o <= chunk_addr_i;
          req_off_o  <= offset;
          req_len_o  <= chunk_len_i;
        end
        default: begin
          if (state == S_WAIT && ack_i) begin
            state        <= S_IDLE;
            req_o        <= 1'b0;
            resp_valid_o <= 1'b1;
            dma_end_o    <= 1'b1;
            if (err_i) begin
              resp_code_o <= RSP_ERR;
              err_o       <= 1'b1;
              active_o    <= 1'b0;
              status_o    <= ST_FAIL;
            end else if (copy_q || ended) begin
              resp_code_o <= RSP_DONE;
              active_o    <= 1'b0;
              if (kind_q) ok_o <= 1'b1;
              else begin
                irq_o    <= 1'b1;
                status_o <= ST_DONE;
              end
            end else begin
              resp_code_o <= RSP_BURST;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq #(
  parameter int SECT_W = 8,
  parameter int LEN_W  = 16,
  parameter int LBA_W  = 24,
  parameter int ADDR_W = 32,
  localparam int CNT_W = (SECT_W + 10 > LEN_W + 2) ? SECT_W + 10 : LEN_W + 2,
  localparam int OFF_W = ((LBA_W + 11 > CNT_W) ? LBA_W + 11 : CNT_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              kind_i,
  input  logic [SECT_W-1:0] nsect_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [1:0]        cmd_i,
  output logic              kick_o,
  output logic              active_o,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  output logic              resp_valid_o,
  output logic [2:0]        resp_code_o,
  output logic              dma_end_o,
  output logic              req_o,
  output logic [1:0]        req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [OFF_W-1:0]  req_off_o,
  output logic [LEN_W-1:0]  req_len_o,
  input  logic              ack_i,
  input  logic              err_i,
  output logic              irq_o,
  output logic              ok_o,
  output logic              err_o,
  output logic [7:0]        status_o,
  output logic [CNT_W-1:0]  dbg_rem_o,
  output logic [CNT_W-1:0]  dbg_idx_o
);
  logic signed [CNT_W-1:0] rem;
  logic [CNT_W-1:0]        idx;
  logic [OFF_W-1:0]        offset;
  logic                    kind_q;
  logic [LBA_W-1:0]        lba_q;
  logic                    cnt_load, cnt_sub, cnt_clamp;
  logic [LEN_W-1:0]        copy_len;

  ide_dma_count #(.SECT_W(SECT_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst),
    .load(cnt_load), .load_kind(kind_i), .load_nsect(nsect_i), .load_pkt(pkt_len_i),
    .sub_en(cnt_sub), .sub_len(chunk_len_i),
    .clamp_en(cnt_clamp), .clamp_len(copy_len),
    .rem(rem), .idx(idx)
  );

  ide_dma_offset #(.LBA_W(LBA_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_offset (
    .optical(kind_q), .lba(lba_q), .idx(idx), .offset(offset)
  );

  ide_dma_ctrl #(
    .LEN_W(LEN_W), .LBA_W(LBA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .start_i(start_i), .kind_i(kind_i), .lba_i(lba_i), .cmd_i(cmd_i),
    .chunk_valid_i(chunk_valid_i), .chunk_addr_i(chunk_addr_i), .chunk_len_i(chunk_len_i),
    .ack_i(ack_i), .err_i(err_i),
    .rem(rem), .offset(offset),
    .kind_q(kind_q), .lba_q(lba_q),
    .cnt_load(cnt_load), .cnt_sub(cnt_sub), .cnt_clamp(cnt_clamp), .copy_len(copy_len),
    .kick_o(kick_o), .active_o(active_o),
    .resp_valid_o(resp_valid_o), .resp_code_o(resp_code_o), .dma_end_o(dma_end_o),
    .req_o(req_o), .req_op_o(req_op_o), .req_addr_o(req_addr_o),
    .req_off_o(req_off_o), .req_len_o(req_len_o),
    .irq_o(irq_o), .ok_o(ok_o), .err_o(err_o), .status_o(status_o)
  );

  assign dbg_rem_o = rem;
  assign dbg_idx_o = idx;
endmodule

// File: rtl/ide_dma_seq_chk.sv
module ide_dma_seq_chk #(
  parameter int SECT_W = 8,
  parameter int LEN_W  = 16,
  parameter int LBA_W  = 24,
  localparam int CNT_W = (SECT_W + 10 > LEN_W + 2) ? SECT_W + 10 : LEN_W + 2,
  localparam int OFF_W = ((LBA_W + 11 > CNT_W) ? LBA_W + 11 : CNT_W) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             kick_o,
  input logic             active_o,
  input logic             resp_valid_o,
  input logic [2:0]       resp_code_o,
  input logic             dma_end_o,
  input logic             req_o,
  input logic [1:0]       req_op_o,
  input logic [OFF_W-1:0] req_off_o,
  input logic [LEN_W-1:0] req_len_o,
  input logic             ack_i,
  input logic             irq_o,
  input logic             ok_o,
  input logic             err_o,
  input logic [7:0]       status_o
);
  // R2
  kick_armed_chk: assert property (@(posedge clk) disable iff (rst)
    kick_o |-> (active_o && status_o == 8'h80));

  // R3
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid_o && resp_code_o == 3'd1) |-> (!dma_end_o && !req_o));

  // R5
  end_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid_o && resp_code_o != 3'd1) |-> dma_end_o);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(req_off_o) && $stable(req_len_o)));

  // R4
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o || ok_o) |-> (!active_o && resp_code_o == 3'd3));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (status_o == 8'h41 && !active_o && resp_code_o == 3'd4));

  // R9
  copy_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && req_op_o == 2'd3) |-> (req_off_o == '0));
endmodule

bind ide_dma_seq ide_dma_seq_chk #(.SECT_W(SECT_W), .LEN_W(LEN_W), .LBA_W(LBA_W)) u_chk (
  .clk(clk), .rst(rst), .kick_o(kick_o), .active_o(active_o),
  .resp_valid_o(resp_valid_o), .resp_code_o(resp_code_o), .dma_end_o(dma_end_o),
  .req_o(req_o), .req_op_o(req_op_o), .req_off_o(req_off_o), .req_len_o(req_len_o),
  .ack_i(ack_i), .irq_o(irq_o), .ok_o(ok_o), .err_o(err_o), .status_o(status_o)
);

// File: tb/test_ide_dma_seq.sv
module test_ide_dma_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SECT_W = 4;
  localparam int LEN_W  = 12;
  localparam int LBA_W  = 8;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = (SECT_W + 10 > LEN_W + 2) ? SECT_W + 10 : LEN_W + 2;
  localparam int OFF_W  = ((LBA_W + 11 > CNT_W) ? LBA_W + 11 : CNT_W) + 1;

  typedef struct packed {
    int kind; int nsect; int pkt; int lba; int cmd; int len;
    int op; int off; int rem; int resp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{0,  2,    0,   3, 0,  512, 0,   1536,  512, 2},
    '{0,  1,    0,   5, 1,  512, 1,   2560,    0, 3},
    '{0,  4,    0,   0, 2,  100, 2,      0, 1948, 2},
    '{1,  0, 2048,   2, 0, 2048, 0,   4096,    0, 3},
    '{1,  0, 3000,   1, 3, 1000, 0,   2048, 2000, 2},
    '{0, 15,    0, 255, 0, 4095, 0, 130560, 3585, 2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, kind_i = 0;
  logic [SECT_W-1:0] nsect_i = '0;
  logic [LEN_W-1:0]  pkt_len_i = '0;
  logic [LBA_W-1:0]  lba_i = '0;
  logic [1:0]        cmd_i = '0;
  logic              chunk_valid_i = 0;
  logic [ADDR_W-1:0] chunk_addr_i = '0;
  logic [LEN_W-1:0]  chunk_len_i = '0;
  logic              ack_i = 0, err_i = 0;
  logic kick_o, active_o, resp_valid_o, dma_end_o, req_o, irq_o, ok_o, err_o;
  logic [2:0]        resp_code_o;
  logic [1:0]        req_op_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [OFF_W-1:0]  req_off_o;
  logic [LEN_W-1:0]  req_len_o;
  logic [7:0]        status_o;
  logic [CNT_W-1:0]  dbg_rem_o, dbg_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_dma_seq #(.SECT_W(SECT_W), .LEN_W(LEN_W), .LBA_W(LBA_W), .ADDR_W(ADDR_W)) i_ide_dma_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i), .nsect_i(nsect_i),
    .pkt_len_i(pkt_len_i), .lba_i(lba_i), .cmd_i(cmd_i), .kick_o(kick_o), .active_o(active_o),
    .chunk_valid_i(chunk_valid_i), .chunk_addr_i(chunk_addr_i), .chunk_len_i(chunk_len_i),
    .resp_valid_o(resp_valid_o), .resp_code_o(resp_code_o), .dma_end_o(dma_end_o),
    .req_o(req_o), .req_op_o(req_op_o), .req_addr_o(req_addr_o), .req_off_o(req_off_o),
    .req_len_o(req_len_o), .ack_i(ack_i), .err_i(err_i), .irq_o(irq_o), .ok_o(ok_o),
    .err_o(err_o), .status_o(status_o), .dbg_rem_o(dbg_rem_o), .dbg_idx_o(dbg_idx_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input int kind, input int nsect, input int pkt,
                          input int lba, input int cmd);
    @(negedge clk);
    start_i = 1; kind_i = kind[0]; nsect_i = nsect[SECT_W-1:0];
    pkt_len_i = pkt[LEN_W-1:0]; lba_i = lba[LBA_W-1:0]; cmd_i = cmd[1:0];
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic send_chunk(input int addr, input int len);
    @(negedge clk);
    chunk_valid_i = 1; chunk_addr_i = addr; chunk_len_i = len[LEN_W-1:0];
    @(negedge clk);
    chunk_valid_i = 0;
  endtask

  task automatic do_ack(input bit err);
    ack_i = 1; err_i = err;
    @(negedge clk);
    ack_i = 0; err_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 active", active_o, 0);
    chk("R1 req", req_o, 0);
    chk("R1 resp_valid", resp_valid_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 rem", dbg_rem_o, 0);
    chk("R1 idx", dbg_idx_o, 0);

    // R3 chunk before arming
    send_chunk(32'h40, 64);
    chk("R3 resp", resp_code_o, 1);
    chk("R3 valid", resp_valid_o, 1);
    chk("R3 dma_end", dma_end_o, 0);
    chk("R3 req", req_o, 0);
    chk("R3 rem", dbg_rem_o, 0);

    // table walk: R2 R6 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      do_start(VEC[i].kind, VEC[i].nsect, VEC[i].pkt, VEC[i].lba, VEC[i].cmd);
      chk("R2 kick", kick_o, 1);
      chk("R2 active", active_o, 1);
      chk("R2 rem", dbg_rem_o, VEC[i].kind ? VEC[i].pkt : VEC[i].nsect * 512);
      chk("R2 idx", dbg_idx_o, 0);
      send_chunk(32'h1000 + i, VEC[i].len);
      chk("R6 req", req_o, 1);
      chk("R10 op", req_op_o, VEC[i].op);
      chk("R6 off", req_off_o, VEC[i].off);
      chk("R6 len", req_len_o, VEC[i].len);
      chk("R6 addr", req_addr_o, 32'h1000 + i);
      chk("R7 rem", dbg_rem_o, VEC[i].rem);
      chk("R7 idx", dbg_idx_o, VEC[i].len);
      @(negedge clk);
      chk("R6 held", req_o, 1);
      do_ack(0);
      chk("R8 resp", resp_code_o, VEC[i].resp);
      chk("R8 dma_end", dma_end_o, 1);
      chk("R8 req drop", req_o, 0);
    end

    // R6 R8 R4 two-chunk disk transfer, index advances the offset
    do_start(0, 2, 0, 1, 0);
    send_chunk(32'h2000, 512);
    chk("R6 off first", req_off_o, 512);
    do_ack(0);
    chk("R8 burst", resp_code_o, 2);
    chk("R8 active", active_o, 1);
    send_chunk(32'h2200, 512);
    chk("R6 off second", req_off_o, 1024);
    chk("R7 idx second", dbg_idx_o, 1024);
    do_ack(0);
    chk("R8 done", resp_code_o, 3);
    chk("R4 irq", irq_o, 1);
    chk("R4 status", status_o, 8'h50);
    chk("R4 active", active_o, 0);
    send_chunk(32'h2400, 512);
    chk("R3 after end", resp_code_o, 1);

    // R5 zero-length chunk
    do_start(0, 1, 0, 0, 0);
    send_chunk(32'h3000, 0);
    chk("R5 resp", resp_code_o, 2);
    chk("R5 dma_end", dma_end_o, 1);
    chk("R5 active", active_o, 1);
    chk("R5 rem", dbg_rem_o, 512);
    chk("R5 req", req_o, 0);

    // R4 empty optical, then empty disk
    do_start(1, 0, 0, 4, 0);
    send_chunk(32'h3100, 64);
    chk("R4 opt resp", resp_code_o, 3);
    chk("R4 opt ok", ok_o, 1);
    chk("R4 opt irq", irq_o, 0);
    chk("R4 opt active", active_o, 0);
    do_start(0, 0, 0, 4, 0);
    send_chunk(32'h3200, 64);
    chk("R4 disk irq", irq_o, 1);
    chk("R4 disk status", status_o, 8'h50);
    chk("R4 disk end", dma_end_o, 1);

    // R9 non-block copy, chunk longer than remaining
    do_start(1, 0, 100, 255, 0);
    send_chunk(32'h4000, 300);
    chk("R9 op", req_op_o, 3);
    chk("R9 len", req_len_o, 100);
    chk("R9 off", req_off_o, 0);
    chk("R9 rem", dbg_rem_o, 100);
    chk("R9 err", err_o, 0);
    do_ack(0);
    chk("R9 resp", resp_code_o, 3);
    chk("R9 ok", ok_o, 1);
    chk("R9 active", active_o, 0);
    // R9 chunk shorter than remaining
    do_start(1, 0, 500, 255, 0);
    send_chunk(32'h4100, 200);
    chk("R9 short len", req_len_o, 200);
    chk("R9 short rem", dbg_rem_o, 200);
    do_ack(0);
    chk("R9 short done", resp_code_o, 3);

    // R10 illegal disk command
    do_start(0, 1, 0, 0, 3);
    send_chunk(32'h5000, 512);
    chk("R10 resp", resp_code_o, 4);
    chk("R10 req", req_o, 0);
    chk("R10 err", err_o, 1);
    chk("R10 status", status_o, 8'h41);

    // R12 chunk longer than remaining on block path
    do_start(0, 1, 0, 0, 0);
    send_chunk(32'h5100, 600);
    chk("R12 resp", resp_code_o, 4);
    chk("R12 req", req_o, 0);
    chk("R12 active", active_o, 0);
    chk("R12 rem", dbg_rem_o, 512);

    // R11 backend error
    do_start(0, 2, 0, 0, 1);
    send_chunk(32'h6000, 512);
    chk("R11 req", req_o, 1);
    do_ack(1);
    chk("R11 resp", resp_code_o, 4);
    chk("R11 err", err_o, 1);
    chk("R11 end", dma_end_o, 1);
    chk("R11 status", status_o, 8'h41);
    chk("R11 active", active_o, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule